// File: doc/BRIEF.md
# Propagate Partial SAD Tree

This block scores a 4x4 current block against a vertical strip of candidate reference blocks using the sum of absolute differences (SAD) of 8-bit pixels. The current block is written once into four rows of processing elements, each element keeping one pixel. Reference pixels then arrive one row of four per accepted cycle. That row goes to all four element rows at once. In each element row, a two-level adder tree sums the four absolute differences into a 10-bit row SAD. Partial SADs move down one element row per accepted reference row through 12-bit propagation registers. The bottom register therefore holds a complete candidate SAD that covers four consecutive reference rows.

After a start pulse, the first candidate comes out once four rows have been accepted. From then on, every further accepted row yields one more candidate. A tracker keeps the smallest SAD seen since start, together with that candidate's index. A done pulse marks the point where the candidate carrying the final row has been folded into the minimum. The surrounding search controller steps the strip horizontally and supplies the rows.

Top module: `ppsad_tree`

## Requirements
- R1: A write with `cur_we` high stores `cur_pix` into the element at row `cur_addr[3:2]`, column `cur_addr[1:0]`. The pixel stays there until it is written again, so a new block can be loaded between searches.
- R2: Column c of a reference row is carried on `ref_row[8c+7:8c]`. Candidate n is built from accepted rows n to n+3 counted from start, and its SAD is the exact sum over r and c of |cur[r][c] − row(n+r)[c]|. The sum is 12 bits wide, so the maximum of 4080 does not wrap.
- R3: `cand_valid` is high for exactly one cycle, in the cycle after each accepted row whose index since start is 3 or more. Rows 0 to 2 produce no candidate.
- R4: A cycle with `ref_valid` low produces no candidate and disturbs no partial sum. Idle gaps between rows do not change any SAD.
- R5: `cand_idx` is 0 for the first candidate after start and rises by one for each following candidate.
- R6: One cycle after each candidate, `best_sad`/`best_idx` hold the smallest SAD among all candidates since start and that candidate's index.
- R7: On equal SADs, the candidate with the lower index is kept.
- R8: `done` pulses for one cycle, two cycles after the row presented with `ref_last` is accepted, provided that row produced a candidate. `best_sad`/`best_idx` are final in that cycle.
- R9: `start` flushes the partial sums, the index counter and the tracker (`best_sad` = 4095, `best_idx` = 0). A reference row presented in the same cycle as `start` is discarded.
- R10: Right after reset, `cand_valid` and `done` are 0, `best_sad` is 4095 and `best_idx` is 0.
- R11: If `ref_last` arrives on one of the first three rows, no candidate and no `done` are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new search; flushes pipeline and tracker |
| cur_we | input | 1 | Current-block pixel write strobe |
| cur_addr | input | 4 | Element address, row*4 + column |
| cur_pix | input | 8 | Current-block pixel value |
| ref_valid | input | 1 | Reference row present this cycle |
| ref_last | input | 1 | Marks the final reference row of the strip |
| ref_row | input | 32 | Four reference pixels, column c in bits 8c+7:8c |
| cand_valid | output | 1 | Candidate SAD valid pulse |
| cand_sad | output | 12 | Candidate SAD |
| cand_idx | output | 8 | Candidate index since start |
| best_sad | output | 12 | Minimum SAD since start |
| best_idx | output | 8 | Index of the minimum-SAD candidate |
| done | output | 1 | Search finished pulse |

## Verification
Several search cases target specific mistakes:

- Reference strips that repeat the current block give several zero-SAD candidates. A tracker that compares with less-or-equal would report a later index instead of 0.
- A saturated block (all 255 against all 0) gives 4080. Any sum narrower than 12 bits would wrap on that value.
- Strips that end with an exact match put the minimum on the last candidate. A done pulse issued one cycle early would expose a stale minimum.
- Idle gaps between rows catch a pipeline that advances without data. Such a design would emit spurious candidates or shifted sums.
- A row sent together with start catches a flush that still lets that row in. The sums would be wrong, or the minimum would not return to 4095.
- A three-row strip catches a design that raises done without any candidate.

// File: rtl/ppsad_pkg.sv
package ppsad_pkg;

    localparam int PIX_W  = 8;
    localparam int BLK    = 4;
    localparam int ROW_W  = PIX_W + $clog2(BLK);
    localparam int ACC_W  = ROW_W + $clog2(BLK);
    localparam int ADDR_W = 2 * $clog2(BLK);

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [ROW_W-1:0] rsad_t;
    typedef logic [ACC_W-1:0] acc_t;

    // One propagation register between element rows.
    typedef struct packed {
        logic vld;
        logic last;
        acc_t psad;
    } stage_t;

    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic acc_t widen(input rsad_t v);
        return {{(ACC_W-ROW_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/ppsad_row.sv
module ppsad_row
    import ppsad_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [$clog2(BLK)-1:0] wr_col,
    input  pix_t                 wr_pix,
    input  logic [BLK*PIX_W-1:0] ref_row,
    output rsad_t                row_sad
);
    localparam int HALF = BLK / 2;
    localparam int PR_W = PIX_W + 1;

    pix_t              cur_q [BLK];
    pix_t              ad    [BLK];
    logic [PR_W-1:0]   pr    [HALF];

    // Element storage: one current pixel per element.
    for (genvar c = 0; c < BLK; c++) begin : g_pe
        always_ff @(posedge clk) begin
            if (rst)
                cur_q[c] <= '0;
            else if (wr_en && wr_col == c[$clog2(BLK)-1:0])
                cur_q[c] <= wr_pix;
        end
        assign ad[c] = abs_diff(cur_q[c], ref_row[c*PIX_W +: PIX_W]);
    end

    // First tree level: neighbouring pairs.
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        assign pr[p] = {1'b0, ad[2*p]} + {1'b0, ad[2*p+1]};
    end

    // Second tree level: pair sums.
    always_comb begin
        row_sad = '0;
        for (int p = 0; p < HALF; p++)
            row_sad = row_sad + {{(ROW_W-PR_W){1'b0}}, pr[p]};
    end

endmodule

// File: rtl/ppsad_min.sv
module ppsad_min
    import ppsad_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             in_vld,
    input  logic             in_last,
    input  acc_t             in_sad,
    input  logic [IDX_W-1:0] in_idx,
    output acc_t             best_sad,
    output logic [IDX_W-1:0] best_idx,
    output logic             done
);
    logic have_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q   <= 1'b0;
            best_sad <= '1;
            best_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= in_vld & in_last;
            // Strict less-than keeps the earlier candidate on a tie.
            if (in_vld && (!have_q || in_sad < best_sad)) begin
                have_q   <= 1'b1;
                best_sad <= in_sad;
                best_idx <= in_idx;
            end
        end
    end

    a_r6_min_not_above: assert property (@(posedge clk) disable iff (rst)
        in_vld && !clear |=> best_sad <= $past(in_sad));

    a_r7_tie_keeps_earlier: assert property (@(posedge clk) disable iff (rst)
        in_vld && !clear && have_q && in_sad == best_sad |=> best_idx == $past(best_idx));

    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_vld && in_last && !clear));

endmodule

// File: rtl/ppsad_tree.sv
module ppsad_tree
    import ppsad_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 cur_we,
    input  logic [ADDR_W-1:0]    cur_addr,
    input  logic [PIX_W-1:0]     cur_pix,
    input  logic                 ref_valid,
    input  logic                 ref_last,
    input  logic [BLK*PIX_W-1:0] ref_row,
    output logic                 cand_valid,
    output logic [ACC_W-1:0]     cand_sad,
    output logic [IDX_W-1:0]     cand_idx,
    output logic [ACC_W-1:0]     best_sad,
    output logic [IDX_W-1:0]     best_idx,
    output logic                 done
);
    localparam int CW = $clog2(BLK);

    rsad_t            row_sad [BLK];
    stage_t           stg     [BLK];
    logic [IDX_W-1:0] nxt_idx;
    logic [IDX_W-1:0] idx_q;
    logic             accept;

    assign accept = ref_valid && !start;

    // Element rows with broadcast reference row.
    for (genvar r = 0; r < BLK; r++) begin : g_row
        ppsad_row u_row (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cur_we && cur_addr[ADDR_W-1:CW] == r[CW-1:0]),
            .wr_col  (cur_addr[CW-1:0]),
            .wr_pix  (cur_pix),
            .ref_row (ref_row),
            .row_sad (row_sad[r])
        );
    end

    // Vertical propagation of partial SADs.
    for (genvar r = 0; r < BLK; r++) begin : g_stage
        if (r == 0) begin : g_top
            always_ff @(posedge clk) begin
                if (rst || start)
                    stg[r] <= '0;
                else if (accept) begin
                    stg[r].vld  <= 1'b1;
                    stg[r].last <= 1'b0;
                    stg[r].psad <= widen(row_sad[r]);
                end
            end
        end else if (r < BLK - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (rst || start)
                    stg[r] <= '0;
                else if (accept) begin
                    stg[r].vld  <= stg[r-1].vld;
                    stg[r].last <= 1'b0;
                    stg[r].psad <= stg[r-1].psad + widen(row_sad[r]);
                end
            end
        end else begin : g_out
            // Bottom stage emits a one-cycle candidate.
            always_ff @(posedge clk) begin
                if (rst || start)
                    stg[r] <= '0;
                else if (accept) begin
                    stg[r].vld  <= stg[r-1].vld;
                    stg[r].last <= ref_last;
                    stg[r].psad <= stg[r-1].psad + widen(row_sad[r]);
                end else
                    stg[r].vld  <= 1'b0;
            end
        end
    end

    // Candidate numbering.
    always_ff @(posedge clk) begin
        if (rst || start) begin
            nxt_idx <= '0;
            idx_q   <= '0;
        end else if (accept && stg[BLK-2].vld) begin
            idx_q   <= nxt_idx;
            nxt_idx <= nxt_idx + 1'b1;
        end
    end

    assign cand_valid = stg[BLK-1].vld;
    assign cand_sad   = stg[BLK-1].psad;
    assign cand_idx   = idx_q;

    ppsad_min #(.IDX_W(IDX_W)) u_min (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .in_vld   (stg[BLK-1].vld),
        .in_last  (stg[BLK-1].last),
        .in_sad   (stg[BLK-1].psad),
        .in_idx   (idx_q),
        .best_sad (best_sad),
        .best_idx (best_idx),
        .done     (done)
    );

    a_r3_cand_needs_row: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> $past(ref_valid && !start));

    a_r4_idle_no_cand: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> !cand_valid);

    a_r9_start_flushes: assert property (@(posedge clk) disable iff (rst)
        start |=> !cand_valid && !done && best_sad == '1);

endmodule

// File: tb/ppsad_tree_bench.sv
module ppsad_tree_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cur_we = 1'b0;
    logic [3:0]  cur_addr = '0;
    logic [7:0]  cur_pix = '0;
    logic        ref_valid = 1'b0;
    logic        ref_last = 1'b0;
    logic [31:0] ref_row = '0;
    logic        cand_valid;
    logic [11:0] cand_sad;
    logic [7:0]  cand_idx;
    logic [11:0] best_sad;
    logic [7:0]  best_idx;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0] cm [4][4];
    logic [7:0] rm [16][4];

    always #2 clk = ~clk;

    ppsad_tree u_ppsad_tree (
        .clk, .rst, .start, .cur_we, .cur_addr, .cur_pix,
        .ref_valid, .ref_last, .ref_row,
        .cand_valid, .cand_sad, .cand_idx, .best_sad, .best_idx, .done
    );

    // Fields: mode[27:26] gap[25] junk[24] cseed[23:16] rseed[15:8] rows[7:0]
    // mode 0 random, 1 repeats current block, 2 saturated, 3 match at end
    localparam logic [27:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 8'd3,  8'd5,  8'd4},
        {2'd0, 1'b0, 1'b0, 8'd17, 8'd41, 8'd10},
        {2'd1, 1'b0, 1'b0, 8'd9,  8'd0,  8'd12},
        {2'd2, 1'b0, 1'b0, 8'd0,  8'd0,  8'd6},
        {2'd3, 1'b1, 1'b0, 8'd77, 8'd29, 8'd9},
        {2'd0, 1'b0, 1'b1, 8'd51, 8'd88, 8'd7},
        {2'd0, 1'b0, 1'b0, 8'd12, 8'd13, 8'd3},
        {2'd3, 1'b0, 1'b1, 8'd200,8'd150,8'd16}
    };

    function automatic logic [7:0] gp(input int s, input int i);
        int v;
        v = s * 37 + i * 113 + i * i * 7 + 11;
        return v[7:0];
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic int model_sad(input int n);
        int s;
        s = 0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                s += (cm[r][c] > rm[n+r][c]) ? int'(cm[r][c] - rm[n+r][c])
                                             : int'(rm[n+r][c] - cm[r][c]);
        return s;
    endfunction

    task automatic run_search(input logic [27:0] v);
        int mode, cs, rs, n, bsad, bidx, s;
        bit gap, junk;
        mode = int'(v[27:26]); gap = v[25]; junk = v[24];
        cs = int'(v[23:16]); rs = int'(v[15:8]); n = int'(v[7:0]);
        // build model
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                cm[r][c] = (mode == 2) ? 8'hFF : gp(cs, r * 4 + c);
        for (int k = 0; k < n; k++)
            for (int c = 0; c < 4; c++) begin
                if (mode == 1)      rm[k][c] = cm[k % 4][c];
                else if (mode == 2) rm[k][c] = 8'h00;
                else if (mode == 3 && k >= n - 4) rm[k][c] = cm[k - (n - 4)][c];
                else                rm[k][c] = gp(rs, 16 + k * 4 + c);
            end
        // R1: load current block (address = row*4 + column)
        for (int a = 0; a < 16; a++) begin
            cur_we = 1'b1; cur_addr = 4'(a); cur_pix = cm[a / 4][a % 4];
            tick();
        end
        cur_we = 1'b0;
        // start, optionally with a junk row (R9)
        start = 1'b1;
        if (junk) begin ref_valid = 1'b1; ref_row = '1; end
        tick();
        start = 1'b0; ref_valid = 1'b0;
        chk(cand_valid == 1'b0, "R9 no cand after start", int'(cand_valid), 0);
        chk(best_sad == 12'd4095, "R9 best cleared", int'(best_sad), 4095);
        bsad = 4096; bidx = 0;
        for (int k = 0; k < n; k++) begin
            ref_valid = 1'b1; ref_last = (k == n - 1);
            for (int c = 0; c < 4; c++) ref_row[c*8 +: 8] = rm[k][c];
            tick();
            if (k >= 3) begin
                s = model_sad(k - 3);
                chk(cand_valid == 1'b1, "R3 cand_valid", int'(cand_valid), 1);
                chk(int'(cand_sad) == s, "R2 cand_sad", int'(cand_sad), s);
                chk(int'(cand_idx) == k - 3, "R5 cand_idx", int'(cand_idx), k - 3);
                if (s < bsad) begin bsad = s; bidx = k - 3; end
            end else begin
                chk(cand_valid == 1'b0, "R3/R11 no early cand", int'(cand_valid), 0);
            end
            if (gap && (k % 2 == 0) && k != n - 1) begin
                ref_valid = 1'b0; ref_last = 1'b0;
                tick();
                chk(cand_valid == 1'b0, "R4 idle no cand", int'(cand_valid), 0);
            end
        end
        ref_valid = 1'b0; ref_last = 1'b0;
        tick();
        if (n >= 4) begin
            chk(done == 1'b1, "R8 done pulse", int'(done), 1);
            chk(int'(best_sad) == bsad, "R6 best_sad", int'(best_sad), bsad);
            chk(int'(best_idx) == bidx, "R6/R7 best_idx", int'(best_idx), bidx);
        end else begin
            chk(done == 1'b0, "R11 no done", int'(done), 0);
        end
        tick();
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
                summary();
            end
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        // R10 reset state
        chk(cand_valid == 1'b0, "R10 cand_valid", int'(cand_valid), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
        chk(best_sad == 12'd4095, "R10 best_sad", int'(best_sad), 4095);
        chk(best_idx == 8'd0, "R10 best_idx", int'(best_idx), 0);
        for (int i = 0; i < 8; i++) run_search(VEC[i]);
        // directed: repeated-block tie with gaps (R7, R4)
        run_search({2'd1, 1'b1, 1'b1, 8'd99, 8'd0, 8'd13});
        // directed: saturated block in a minimal strip (R2 no wrap)
        run_search({2'd2, 1'b0, 1'b0, 8'd0, 8'd0, 8'd4});
        summary();
    end

endmodule